// File: doc/BRIEF.md
# T1/E1 Transmit Channel Timing Generator

This block follows the bit and timeslot position inside a T1 or E1 transmit frame. It runs from the transmit bit clock and is aligned by a frame-sync pulse. From that position it drives two per-channel timing outputs.

The first output is a channel clock. By default it is a strobe that is high for the last bit (the LSB) of each timeslot. For any channel whose gate bit is set, it becomes a copy of the bit clock for all eight bits of that channel instead. The second output is a channel-block signal, which follows a per-channel mask bit. An external shifter can use these outputs for parallel-to-serial conversion, and a serial controller can use them to pick out the timeslots of a fractional service.

The block also captures the serial transmit data on the falling clock edge. The current position is available at the ports as a framing-bit flag, a channel index and a bit index. The two 32-bit masks are loaded through a synchronous parallel write port.

Top module: `tx_chan_timer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the position goes to the start of a frame in the mode on `mode_e1_i`: `fbit_o`=1 for T1 and 0 for E1, with `chan_o`=0 and `bit_o`=0. Both masks clear, so `chblk_o` is low and channel clocks are strobes. `ser_o` reads 0 after a falling edge with reset low.
- R2: In T1 mode (`mode_e1_i`=0) a frame is 193 bit periods long. The first is the framing bit (`fbit_o`=1, `chan_o`=0, `bit_o`=0). Then come channels 0 to 23, each with `bit_o` counting 0 (MSB) to 7 (LSB).
- R3: In E1 mode (`mode_e1_i`=1) a frame is 256 bit periods long: channels 0 to 31 of 8 bits each, with `fbit_o` always 0.
- R4: For a channel whose gate bit is 0, `chclk_o` is high for the whole bit period with `bit_o`=7, in both clock phases. It is low for every other bit of that channel.
- R5: For a channel whose gate bit is 1, `chclk_o` equals the bit clock during all eight bit periods of that channel: high in the high phase and low in the low phase.
- R6: Outside the framing bit, `chblk_o` equals the block-mask bit whose index is the current channel.
- R7: During the T1 framing bit, `chclk_o` and `chblk_o` stay low whatever the masks hold.
- R8: If `fsync_i` is high at a rising edge, the next bit period is the first bit of a frame (the framing bit in T1, channel 0 bit 0 in E1), from any position.
- R9: A change on `mode_e1_i` is taken only when a new frame starts, either by wrap-around or by `fsync_i`. Until then the running frame keeps its geometry.
- R10: `wr_en_i` high at a rising edge loads `wr_data_i` into the block mask (`wr_sel_i`=0) or the gate mask (`wr_sel_i`=1), effective from the next bit period. In T1 mode, mask bits 24 to 31 have no effect on the outputs.
- R11: `ser_o` holds the value of `ser_i` sampled at the most recent falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_i | input | 1 | Frame alignment pulse; restarts the frame |
| mode_e1_i | input | 1 | Line mode: 0 = T1, 1 = E1 |
| wr_en_i | input | 1 | Mask write strobe |
| wr_sel_i | input | 1 | Mask select: 0 = block mask, 1 = gate mask |
| wr_data_i | input | 32 | Mask write data, bit n for channel n |
| ser_i | input | 1 | Serial transmit data |
| chclk_o | output | 1 | Channel LSB strobe or gated bit clock |
| chblk_o | output | 1 | Per-channel block output |
| ser_o | output | 1 | Serial data captured on the falling edge |
| fbit_o | output | 1 | High during the T1 framing bit |
| chan_o | output | 5 | Current channel index |
| bit_o | output | 3 | Current bit within the channel, 0 = MSB |

## Verification
The position counter is visible at the ports in every bit period. A miscount, a wrong wrap point or a missed realignment therefore shows at the ports within one bit period of the fault. A mode latched at the wrong time shows at the next frame boundary, because the frame length or the framing bit then differs. A corrupted mask bit shows on `chblk_o` or `chclk_o` within the eight bits of the affected channel, so at most one frame later. Both clock phases are sampled, which separates a strobe from a gated clock.

// File: rtl/tcg_pkg.sv
// Shared geometry constants and types for the transmit channel timing
// generator. Assumes at most 32 channels of 8 bits per frame.
package tcg_pkg;

    localparam int TCG_MAX_CH      = 32;
    localparam int TCG_BITS_PER_CH = 8;
    localparam int TCG_CH_W        = $clog2(TCG_MAX_CH);
    localparam int TCG_BIT_W       = $clog2(TCG_BITS_PER_CH);

    typedef enum logic {
        MODE_T1 = 1'b0,
        MODE_E1 = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic                 fbit;
        logic [TCG_CH_W-1:0]  chan;
        logic [TCG_BIT_W-1:0] bitn;
    } slot_pos_t;

endpackage

// File: rtl/tcg_slot_counter.sv
// Frame position counter. It tracks the framing bit, the channel and the bit
// within the channel. It restarts on frame sync or at the end of a frame, and
// it latches the line mode only at those restarts.
// Assumes T1_CHANS <= E1_CHANS <= TCG_MAX_CH.
module tcg_slot_counter
    import tcg_pkg::*;
#(
    parameter int T1_CHANS = 24,
    parameter int E1_CHANS = TCG_MAX_CH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync_i,
    input  line_mode_e mode_i,
    output slot_pos_t  pos_o,
    output line_mode_e mode_o
);

    localparam logic [TCG_CH_W-1:0]  T1_LAST  = TCG_CH_W'(T1_CHANS - 1);
    localparam logic [TCG_CH_W-1:0]  E1_LAST  = TCG_CH_W'(E1_CHANS - 1);
    localparam logic [TCG_BIT_W-1:0] LSB_SLOT = TCG_BIT_W'(TCG_BITS_PER_CH - 1);

    slot_pos_t             pos_q;
    line_mode_e            mode_q;
    logic [TCG_CH_W-1:0]   last_chan;
    logic                  frame_end;
    logic                  restart;

    // First position of a frame for a given mode.
    function automatic slot_pos_t start_pos(input line_mode_e m);
        slot_pos_t p;
        p.fbit = (m == MODE_T1);
        p.chan = '0;
        p.bitn = '0;
        return p;
    endfunction

    // Detect the last bit of the frame and any restart.
    always_comb begin
        last_chan = (mode_q == MODE_E1) ? E1_LAST : T1_LAST;
        frame_end = !pos_q.fbit && (pos_q.bitn == LSB_SLOT) && (pos_q.chan == last_chan);
        restart   = fsync_i || frame_end;
    end

    // Advance the position; latch the mode at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_i;
            pos_q  <= start_pos(mode_i);
        end else if (restart) begin
            mode_q <= mode_i;
            pos_q  <= start_pos(mode_i);
        end else if (pos_q.fbit) begin
            pos_q.fbit <= 1'b0;
            pos_q.chan <= '0;
            pos_q.bitn <= '0;
        end else if (pos_q.bitn == LSB_SLOT) begin
            pos_q.bitn <= '0;
            pos_q.chan <= pos_q.chan + 1'b1;
        end else begin
            pos_q.bitn <= pos_q.bitn + 1'b1;
        end
    end

    assign pos_o  = pos_q;
    assign mode_o = mode_q;

    AST_T1_CHAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_T1) |-> (pos_q.chan <= T1_LAST)); // R2

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q.chan != '0 || pos_q.bitn != '0) |-> $stable(mode_q)); // R9

    AST_E1_NO_FBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_E1) |-> !pos_q.fbit); // R3

endmodule

// File: rtl/tcg_chan_mask.sv
// Per-channel block and gate masks, loaded through a synchronous parallel
// write port. Assumes one write per cycle; wr_sel_i picks the target.
module tcg_chan_mask
    import tcg_pkg::*;
#(
    parameter int NUM_CH = TCG_MAX_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [NUM_CH-1:0] wr_data_i,
    output logic [NUM_CH-1:0] blk_mask_o,
    output logic [NUM_CH-1:0] gate_mask_o
);

    logic [NUM_CH-1:0] blk_q;
    logic [NUM_CH-1:0] gate_q;

    // Clear on reset; load the selected mask on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            gate_q <= '0;
        end else if (wr_en_i) begin
            if (wr_sel_i) begin
                gate_q <= wr_data_i;
            end else begin
                blk_q <= wr_data_i;
            end
        end
    end

    assign blk_mask_o  = blk_q;
    assign gate_mask_o = gate_q;

    AST_BLK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (blk_q == $past(wr_data_i))); // R10

    AST_GATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i) |=> (gate_q == $past(wr_data_i) && $stable(blk_q))); // R10

endmodule

// File: rtl/tcg_chan_out.sv
// Per-channel output stage. It decodes the current channel to a one-hot
// select, picks that channel's mask bits, and forms the channel clock (LSB
// strobe or gated bit clock) and the block output. Outputs are quiet during
// the framing bit. Assumes pos_i changes only on rising edges of bit_clk.
module tcg_chan_out
    import tcg_pkg::*;
#(
    parameter int NUM_CH = TCG_MAX_CH
) (
    input  logic              bit_clk,
    input  slot_pos_t         pos_i,
    input  logic [NUM_CH-1:0] blk_mask_i,
    input  logic [NUM_CH-1:0] gate_mask_i,
    output logic              chclk_o,
    output logic              chblk_o
);

    localparam logic [TCG_BIT_W-1:0] LSB_SLOT = TCG_BIT_W'(TCG_BITS_PER_CH - 1);

    logic [NUM_CH-1:0] chan_sel;
    logic              gate_hit;
    logic              blk_hit;
    logic              lsb_now;
    logic              slot_active;

    // One-hot decode of the current channel index.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign chan_sel[g] = (pos_i.chan == TCG_CH_W'(g));
    end

    // Select the channel's mask bits and form both outputs.
    always_comb begin
        gate_hit    = |(chan_sel & gate_mask_i);
        blk_hit     = |(chan_sel & blk_mask_i);
        lsb_now     = (pos_i.bitn == LSB_SLOT);
        slot_active = !pos_i.fbit;
        chclk_o     = slot_active && (gate_hit ? bit_clk : lsb_now);
        chblk_o     = slot_active && blk_hit;
    end

endmodule

// File: rtl/tcg_ser_capture.sv
// Captures serial transmit data on the falling edge of the bit clock.
// Assumes ser_i is stable around the falling edge.
module tcg_ser_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_i,
    output logic ser_o
);

    logic ser_q;

    // Falling-edge sample with synchronous clear.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ser_q <= 1'b0;
        end else begin
            ser_q <= ser_i;
        end
    end

    assign ser_o = ser_q;

endmodule

// File: rtl/tx_chan_timer.sv
// Top of the transmit channel timing generator. It ties the position counter,
// the mask registers, the per-channel output stage and the serial data capture
// together. Assumes clk is the transmit bit clock of the selected line mode.
module tx_chan_timer
    import tcg_pkg::*;
#(
    parameter int T1_CHANS = 24,
    parameter int E1_CHANS = TCG_MAX_CH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fsync_i,
    input  logic                  mode_e1_i,
    input  logic                  wr_en_i,
    input  logic                  wr_sel_i,
    input  logic [TCG_MAX_CH-1:0] wr_data_i,
    input  logic                  ser_i,
    output logic                  chclk_o,
    output logic                  chblk_o,
    output logic                  ser_o,
    output logic                  fbit_o,
    output logic [TCG_CH_W-1:0]   chan_o,
    output logic [TCG_BIT_W-1:0]  bit_o
);

    slot_pos_t             pos;
    line_mode_e            mode_act;
    logic [TCG_MAX_CH-1:0] blk_mask;
    logic [TCG_MAX_CH-1:0] gate_mask;

    tcg_slot_counter #(
        .T1_CHANS (T1_CHANS),
        .E1_CHANS (E1_CHANS)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync_i),
        .mode_i  (line_mode_e'(mode_e1_i)),
        .pos_o   (pos),
        .mode_o  (mode_act)
    );

    tcg_chan_mask #(
        .NUM_CH (TCG_MAX_CH)
    ) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_sel_i),
        .wr_data_i   (wr_data_i),
        .blk_mask_o  (blk_mask),
        .gate_mask_o (gate_mask)
    );

    tcg_chan_out #(
        .NUM_CH (TCG_MAX_CH)
    ) u_out (
        .bit_clk     (clk),
        .pos_i       (pos),
        .blk_mask_i  (blk_mask),
        .gate_mask_i (gate_mask),
        .chclk_o     (chclk_o),
        .chblk_o     (chblk_o)
    );

    tcg_ser_capture u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .ser_i (ser_i),
        .ser_o (ser_o)
    );

    assign fbit_o = pos.fbit;
    assign chan_o = pos.chan;
    assign bit_o  = pos.bitn;

    AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (chan_o == '0 && bit_o == '0)); // R8

    AST_FBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_o |-> (!chblk_o && !chclk_o)); // R7

    AST_STROBE_AT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (chclk_o && !gate_mask[chan_o]) |-> (bit_o == TCG_BIT_W'(TCG_BITS_PER_CH - 1))); // R4

    AST_FBIT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_o |-> (mode_act == MODE_T1)); // R2

endmodule

// File: tb/tb_tx_chan_timer.sv
`timescale 1ns/1ps
module tb_tx_chan_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fsync_i;
    logic        mode_e1_i;
    logic        wr_en_i;
    logic        wr_sel_i;
    logic [31:0] wr_data_i;
    logic        ser_i;
    logic        chclk_o;
    logic        chblk_o;
    logic        ser_o;
    logic        fbit_o;
    logic [4:0]  chan_o;
    logic [2:0]  bit_o;

    always #2.5 clk = ~clk;

    tx_chan_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync_i   (fsync_i),
        .mode_e1_i (mode_e1_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .ser_i     (ser_i),
        .chclk_o   (chclk_o),
        .chblk_o   (chblk_o),
        .ser_o     (ser_o),
        .fbit_o    (fbit_o),
        .chan_o    (chan_o),
        .bit_o     (bit_o)
    );

    int    n_vec  = 0;
    int    n_miss = 0;
    int    cyc    = 0;
    // Reference model state
    int    m_k    = 0;
    logic  m_mode = 1'b0;
    logic [31:0] m_blk  = '0;
    logic [31:0] m_gate = '0;
    string pos_tag = "";
    string blk_tag = "";

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One bit period: update the model at the rising edge, check both phases.
    task automatic tick();
        int  ch;
        int  bn;
        bit  fb;
        bit  g;
        bit  ser_v;
        string ptag;
        string ctag;
        string btag;
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            m_k = 0; m_mode = mode_e1_i; m_blk = '0; m_gate = '0;
        end else begin
            if (wr_en_i) begin
                if (wr_sel_i) m_gate = wr_data_i; else m_blk = wr_data_i;
            end
            if (fsync_i) begin
                m_k = 0; m_mode = mode_e1_i;
            end else begin
                m_k++;
                if (m_k == (m_mode ? 256 : 193)) begin
                    m_k = 0; m_mode = mode_e1_i;
                end
            end
        end
        #1;
        if (m_mode) begin
            fb = 1'b0; ch = m_k / 8; bn = m_k % 8;
        end else if (m_k == 0) begin
            fb = 1'b1; ch = 0; bn = 0;
        end else begin
            fb = 1'b0; ch = (m_k - 1) / 8; bn = (m_k - 1) % 8;
        end
        g    = m_gate[ch];
        ptag = !rst_n ? "R1" : (pos_tag != "") ? pos_tag : (m_mode ? "R3" : "R2");
        ctag = !rst_n ? "R1" : fb ? "R7" : g ? "R5" : "R4";
        btag = !rst_n ? "R1" : fb ? "R7" : (blk_tag != "") ? blk_tag : "R6";
        chk(ptag, "fbit_o", int'(fbit_o), int'(fb));
        chk(ptag, "chan_o", int'(chan_o), ch);
        chk(ptag, "bit_o", int'(bit_o), bn);
        chk(ctag, "chclk_o high phase", int'(chclk_o), int'(!fb && (g || bn == 7)));
        chk(btag, "chblk_o", int'(chblk_o), int'(!fb && m_blk[ch]));
        ser_v = ((cyc * 5) >> 2) & 1;
        ser_v = ser_v ^ cyc[4];
        ser_i = ser_v;
        @(negedge clk);
        #1;
        chk(ctag, "chclk_o low phase", int'(chclk_o), int'(!fb && !g && bn == 7));
        chk(!rst_n ? "R1" : "R11", "ser_o", int'(ser_o), !rst_n ? 0 : int'(ser_v));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_mask(input logic sel, input logic [31:0] val);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = val;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic pulse_fsync();
        fsync_i = 1'b1;
        tick();
        fsync_i = 1'b0;
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    endtask

    initial begin
        #1000000;
        n_miss++;
        $display("FAIL watchdog: actual running, expected finished");
        finish_up();
    end

    initial begin
        rst_n = 1'b0; fsync_i = 1'b0; mode_e1_i = 1'b0;
        wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0; ser_i = 1'b0;
        // R1: reset state, T1 then E1 reset mode
        run(3);
        mode_e1_i = 1'b1; run(2);
        mode_e1_i = 1'b0; run(2);
        rst_n = 1'b1;
        // R2 R4 R6: plain T1 frames with strobes only
        run(200);
        // R10: block mask with upper bits set must not matter in T1
        blk_tag = "R10";
        write_mask(1'b0, 32'hFF00_A5C3);
        write_mask(1'b1, 32'hFF55_AA55);
        run(2 * 193);
        blk_tag = "";
        // R5 R4: inverse gate pattern covers every channel both ways
        write_mask(1'b1, 32'h00AA_55AA);
        write_mask(1'b0, 32'h005A_3C0F);
        run(193);
        // R8: realign in the middle of a T1 frame
        run(37);
        pos_tag = "R8";
        pulse_fsync();
        run(3);
        pos_tag = "";
        run(100);
        // R9: switch to E1 mid-frame; takes effect at the wrap
        pos_tag = "R9";
        mode_e1_i = 1'b1;
        run(200);
        pos_tag = "";
        // R3 R5 R6: E1 frames with two mask patterns
        write_mask(1'b1, 32'h5555_5555);
        write_mask(1'b0, 32'hC3A5_0FF0);
        run(256);
        write_mask(1'b1, 32'hAAAA_AAAA);
        run(256);
        // R8: realign in E1
        run(77);
        pos_tag = "R8";
        pulse_fsync();
        run(3);
        pos_tag = "";
        run(50);
        // R9: back to T1 through a sync pulse
        pos_tag = "R9";
        mode_e1_i = 1'b0;
        run(20);
        pulse_fsync();
        run(5);
        pos_tag = "";
        run(2 * 193);
        finish_up();
    end

endmodule